// File: doc/BRIEF.md
# Per-Lane Vector Shifter

This block shifts every lane of a 64-bit data word by its own amount. The word is cut into either four 16-bit lanes or two 32-bit lanes. Each lane reads its shift amount from the matching lane of a second 64-bit operand. A 9-bit operation code picks the lane width and the shift kind. The four shift kinds are zero-filling left, zero-filling right, sign-filling right, and a signed left shift that clamps to the lane's range when it overflows.

The block fits into the execution stage of a SIMD datapath. Operands and the operation code arrive together. With the default setting, the result and a flag for an unknown operation code come out of one register stage on the next clock edge. A parameter removes that register and makes the path purely combinational.

Top module: `lane_shift_unit`

## Requirements
- R1: When op_i[2]=0 the word is treated as four 16-bit lanes. Lane i occupies bits [16i+15:16i], so lane 0 holds the least significant bits, and each lane is computed independently of the others.
- R2: When op_i[2]=1 the word is treated as two 32-bit lanes. Lane i occupies bits [32i+31:32i].
- R3: Each lane's shift count is taken from the same bit range of src_b_i. Only the low 4 bits (16-bit lanes) or the low 5 bits (32-bit lanes) are used, which gives the count modulo the lane width. Higher bits of that lane of src_b_i have no effect.
- R4: Codes 0x021 (16-bit) and 0x025 (32-bit) shift left, fill with zeros, and drop the bits shifted out, with no saturation.
- R5: Codes 0x023 (16-bit) and 0x027 (32-bit) shift right and fill the vacated high bits with zeros.
- R6: Codes 0x02B (16-bit) and 0x02F (32-bit) shift right and fill the vacated high bits with the lane's sign bit.
- R7: Codes 0x029 (16-bit) and 0x02D (32-bit) shift the signed lane left. If the exact result is above the lane's signed maximum, the lane becomes 0x7FFF or 0x7FFFFFFF. If it is below the signed minimum, the lane becomes 0x8000 or 0x80000000. Otherwise the lane holds the exact result.
- R8: A count of zero, after the modulo, returns the lane unchanged in all four shift kinds.
- R9: Any code other than the eight above drives illegal_o high and the whole result to zero. A listed code drives illegal_o low.
- R10: With REG_OUT=1, res_o and illegal_o show the result for the inputs present at the previous rising clock edge. An active-low rst_n clears both outputs to zero asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 9 | Operation code selecting lane width and shift kind |
| src_a_i | input | 64 | Data lanes to be shifted |
| src_b_i | input | 64 | Per-lane shift counts, aligned with the data lanes |
| res_o | output | 64 | Shifted lanes |
| illegal_o | output | 1 | High when op_i is not one of the eight known codes |

## Verification
A table of hand-worked vectors runs every shift kind at both lane widths. Each vector mixes positive, negative and most-negative lanes, so a wrong lane boundary, a zero fill where a sign fill belongs, or a missed clamp shows up in a single lane. Counts with bits set above the modulo range separate correct truncation from using the full field. Counts of width minus one and zero probe the two ends of the shifter, and saturating vectors land exactly on each limit and just past it. Random operands, including random operation codes, are compared against an integer reference model. Two unknown codes, one with a high bit set and one with bit 0 clear, exercise the illegal path.

// File: rtl/lane_shift_unit.sv
module lane_shift_unit #(
  parameter int DATA_W  = 64,
  parameter int OP_W    = 9,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              illegal_o
);

  localparam int NARROW_W = DATA_W / 4;
  localparam int WIDE_W   = DATA_W / 2;

  logic legal, wide, right, sgn;
  logic [DATA_W-1:0] res_n, res_w, res_d;
  logic unused_cnt_hi;

  assign legal = (op_i[OP_W-1:4] == (OP_W-4)'(2)) && op_i[0];
  assign wide  = op_i[2];
  assign right = op_i[1];
  assign sgn   = op_i[3];
  assign unused_cnt_hi = ^src_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    localparam int NL = DATA_W / LW;
    localparam int SW = $clog2(LW);
    logic [DATA_W-1:0] lanes;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0]   a, sll, srl, sra, sat, sel;
      logic [SW-1:0]   sh;
      logic [2*LW-1:0] ext;
      logic            ovf;

      assign a   = src_a_i[i*LW +: LW];
      assign sh  = src_b_i[i*LW +: SW];
      assign sll = a << sh;
      assign srl = a >> sh;
      assign sra = $signed(a) >>> sh;
      assign ext = {{LW{a[LW-1]}}, a} << sh;
      assign ovf = !(&ext[2*LW-1:LW-1]) && (|ext[2*LW-1:LW-1]);
      assign sat = ovf ? {a[LW-1], {(LW-1){~a[LW-1]}}} : ext[LW-1:0];

      always_comb begin
        case ({sgn, right})
          2'b00:   sel = sll;
          2'b01:   sel = srl;
          2'b10:   sel = sat;
          default: sel = sra;
        endcase
      end

      assign lanes[i*LW +: LW] = sel;

      // R8
      zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh == '0) |-> (sll == a && srl == a && sra == a && sat == a));
      // R7
      sat_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat[LW-1] == a[LW-1]);
      // R6
      sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sra[LW-1] == a[LW-1]);
      // R5
      srl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh != '0) |-> !srl[LW-1]);
    end

    if (g == 0) begin : g_n
      assign res_n = lanes;
    end else begin : g_w
      assign res_w = lanes;
    end
  end

  assign res_d = !legal ? '0 : (wide ? res_w : res_n);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o     <= '0;
        illegal_o <= 1'b0;
      end else begin
        res_o     <= res_d;
        illegal_o <= !legal;
      end
    end

    // R10
    reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (illegal_o == !$past(legal)));
  end else begin : g_comb
    assign res_o     = res_d;
    assign illegal_o = !legal;
  end

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (res_o == '0));

endmodule

// File: tb/lane_shift_unit_test.sv
module lane_shift_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  op = 9'h021;
  logic [63:0] a = 64'h1234_5678_9ABC_DEF0;
  logic [63:0] b = 64'h0001_0002_0003_0004;
  logic [63:0] res;
  logic        ill;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  lane_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .src_a_i(a), .src_b_i(b),
    .res_o(res), .illegal_o(ill)
  );

  localparam int NV = 12;
  // {op, a, b, expected result, expected illegal}
  localparam logic [201:0] VEC [NV] = '{
    {9'h021, 64'h0001_0002_0003_8001, 64'h0000_0001_0004_0011, 64'h0001_0004_0030_0002, 1'b0},
    {9'h023, 64'h8000_FFFF_1234_0001, 64'h000F_0004_0008_0000, 64'h0001_0FFF_0012_0001, 1'b0},
    {9'h02B, 64'h8000_FFFF_1234_0001, 64'h000F_0004_0008_0000, 64'hFFFF_FFFF_0012_0001, 1'b0},
    {9'h029, 64'h8000_C000_4000_0123, 64'h0001_0001_0001_0004, 64'h8000_8000_7FFF_1230, 1'b0},
    {9'h025, 64'h8000_0001_0000_FFFF, 64'h0000_0021_0000_0010, 64'h0000_0002_FFFF_0000, 1'b0},
    {9'h027, 64'h8000_0000_1234_5678, 64'h0000_001F_0000_0004, 64'h0000_0001_0123_4567, 1'b0},
    {9'h02F, 64'h8000_0000_1234_5678, 64'h0000_001F_0000_0004, 64'hFFFF_FFFF_0123_4567, 1'b0},
    {9'h02D, 64'hC000_0000_4000_0000, 64'h0000_0001_0000_0001, 64'h8000_0000_7FFF_FFFF, 1'b0},
    {9'h02D, 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_0000_001E, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0},
    {9'h029, 64'h8000_7FFF_1234_FFFF, 64'h0010_0020_0000_0030, 64'h8000_7FFF_1234_FFFF, 1'b0},
    {9'h0A1, 64'h1111_2222_3333_4444, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, 1'b1},
    {9'h020, 64'h1111_2222_3333_4444, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, 1'b1}
  };
  localparam string VTAG [NV] = '{"R1 R3 R4", "R1 R3 R5", "R1 R6", "R1 R7",
                                  "R2 R3 R4", "R2 R5", "R2 R6", "R2 R7",
                                  "R2 R7", "R3 R8", "R9", "R9"};

  function automatic logic [64:0] model(logic [8:0] o, logic [63:0] x, logic [63:0] y);
    int lw;
    logic [63:0] r;
    logic [63:0] m;
    case (o)
      9'h021, 9'h023, 9'h029, 9'h02B: lw = 16;
      9'h025, 9'h027, 9'h02D, 9'h02F: lw = 32;
      default: return {1'b1, 64'h0};
    endcase
    r = '0;
    m = (64'h1 << lw) - 64'h1;
    for (int i = 0; i < 64 / lw; i++) begin
      longint unsigned v;
      longint sv;
      longint unsigned res_l;
      int sh;
      v = (x >> (i * lw)) & m;
      sh = int'(((y >> (i * lw)) & m) % 64'(lw));
      sv = (v >= (64'h1 << (lw - 1))) ? longint'(v) - longint'(64'h1 << lw) : longint'(v);
      case ({o[3], o[1]})
        2'b00: res_l = (v << sh) & m;
        2'b01: res_l = v >> sh;
        2'b11: res_l = longint'(sv >>> sh) & m;
        default: begin
          longint t;
          longint hi;
          longint lo;
          t  = sv <<< sh;
          hi = (longint'(1) <<< (lw - 1)) - 1;
          lo = -hi - 1;
          if (t > hi) t = hi;
          if (t < lo) t = lo;
          res_l = longint'(t) & m;
        end
      endcase
      r = r | (res_l << (i * lw));
    end
    return {1'b0, r};
  endfunction

  task automatic check(string tag, logic [63:0] er, logic ei);
    checks++;
    if (res !== er || ill !== ei) begin
      failures++;
      $display("FAIL %s: res=%h ill=%b expected res=%h ill=%b", tag, res, ill, er, ei);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [64:0] e;
    repeat (3) @(negedge clk);
    check("R10 reset state", 64'h0, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      op = VEC[k][201:193];
      a  = VEC[k][192:129];
      b  = VEC[k][128:65];
      @(negedge clk);
      check(VTAG[k], VEC[k][64:1], VEC[k][0]);
    end

    // R7 R6 R5 R4: most negative lanes, count width minus one, upper count bits set
    a = 64'h8000_8000_8000_8000; b = 64'hFFFF_FFFF_FFFF_FFFF;
    op = 9'h029; @(negedge clk); check("R7 min lane count 15", 64'h8000_8000_8000_8000, 1'b0);
    op = 9'h021; @(negedge clk); check("R4 min lane count 15", 64'h0, 1'b0);
    op = 9'h02B; @(negedge clk); check("R6 min lane count 15", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    op = 9'h023; @(negedge clk); check("R5 min lane count 15", 64'h0001_0001_0001_0001, 1'b0);
    a = 64'h8000_0000_0000_0001;
    op = 9'h02D; @(negedge clk); check("R7 R2 count 31", 64'h8000_0000_7FFF_FFFF, 1'b0);
    op = 9'h025; @(negedge clk); check("R4 R2 count 31", 64'h0000_0000_8000_0000, 1'b0);

    for (int n = 0; n < 600; n++) begin
      logic [8:0] codes [8];
      codes = '{9'h021, 9'h023, 9'h029, 9'h02B, 9'h025, 9'h027, 9'h02D, 9'h02F};
      op = (n % 10 == 9) ? 9'($urandom) : codes[$urandom % 8];
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      if (n % 4 == 0) a = a | 64'h8000_8000_8000_8000;
      e = model(op, a, b);
      @(negedge clk);
      check("R1 R2 R3 R4 R5 R6 R7 R9 random", e[63:0], e[64]);
    end

    // R10: asynchronous clear after a captured result
    op = 9'h021; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0;
    @(negedge clk);
    check("R10 captured", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    op = 9'h1FF;
    @(negedge clk);
    check("R10 R9 illegal captured", 64'h0, 1'b1);
    op = 9'h021;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", 64'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    summary();
  end

endmodule